// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block turns a master audio tick into a slower sample strobe whose average rate is master × inc / mod. It uses an accumulator in the manner of a line-drawing algorithm. Two master tick enables arrive from outside, one for the 44.1 kHz family and one for the 48 kHz family. Each generator picks one of them. On every selected tick the generator adds its increment to its accumulator. When the sum reaches the modulus, the modulus is subtracted and a single-cycle strobe is raised.

`NUM_GEN` independent generators share one write port. A write names a generator and one of its two configuration registers. The base register chooses the master family. The ratio register holds the increment together with an encoded form of the modulus. Software that wants a rate first clamps the request to 4000..48000 Hz. It then picks the family that divides more evenly, preferring 44.1 kHz on ties, and programs inc = 4 and mod = 4 × master / rate.

Top module: `rate_strobe_gen`

## Requirements
- R1: After reset every strobe output is low, and in the reset configuration (increment 0, 48 kHz source) no strobe is ever raised, whatever the ticks do.
- R2: Base register (wrReg = 0) bit 0 selects the tick source of the addressed generator: 1 selects tick44 and 0 selects tick48. Ticks on the unselected input have no effect on the strobe or on the accumulator.
- R3: Ratio register (wrReg = 1) holds the increment in bits 15:0 and the field F in bits 31:16. The modulus is (inc − F − 1) mod 65536. This holds for values up to the full 16-bit range.
- R4: Number the selected ticks since the last write to the generator as k = 1, 2, …. With a valid ratio, tick k raises the strobe exactly when floor(k·inc/mod) > floor((k−1)·inc/mod). The strobe is high for exactly the one clock cycle after the edge that took the tick.
- R5: Over N selected ticks after a write, the number of strobes equals floor(N·inc/mod).
- R6: A write to either register of a generator clears its accumulator, so tick numbering restarts at k = 1.
- R7: A modulus of 0, or a modulus smaller than the increment, is invalid and suppresses every strobe.
- R8: When a write and a selected tick fall in the same cycle, the write wins and the tick is discarded.
- R9: A write changes only the generator whose index equals wrIdx. An index of NUM_GEN or above changes none.
- R10: A strobe is raised only in the cycle after a selected tick was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | IDX_W | Generator addressed by the write |
| wrReg | input | 1 | 0 = base register, 1 = ratio register |
| wrData | input | 32 | Write data |
| tick44 | input | 1 | 44.1 kHz family master tick enable |
| tick48 | input | 1 | 48 kHz family master tick enable |
| sampleStrobe | output | NUM_GEN | One-cycle sample strobe per generator |

## Verification
The assertions assume the following about the inputs:
- Tick inputs are single-cycle enables synchronous to clk.
- No write occurs while reset is asserted.
- The configuration registers change only through an addressed write.

The stimulus drives every input half a cycle away from the active edge and issues writes only after reset has been released. It also reaches the cases the assertions depend on: an out-of-range index, a write colliding with a tick, and invalid moduli. A sweep over increments 1..4 and moduli 1..9 on both sources compares each strobe against the floor-difference rule.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int unsigned RATIO_W = 16;
  localparam int unsigned DATA_W  = 2 * RATIO_W;

  typedef enum logic {
    REG_BASE  = 1'b0,
    REG_RATIO = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic               tick;
    logic               clear;
    logic               valid;
    logic [RATIO_W-1:0] inc;
    logic [RATIO_W-1:0] modulus;
  } gen_ctl_t;
endpackage

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
  import rsg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrHit,
  input  reg_sel_e          wrReg,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick44,
  input  logic              tick48,
  output gen_ctl_t          ctl
);
  logic               baseIs44;
  logic [RATIO_W-1:0] incReg;
  logic [RATIO_W-1:0] fieldReg;
  logic [RATIO_W-1:0] modulus;
  logic               ratioOk;
  logic               tickSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseIs44 <= 1'b0;
      incReg   <= '0;
      fieldReg <= '0;
    end else if (wrHit) begin
      case (wrReg)
        REG_BASE:  baseIs44 <= wrData[0];
        REG_RATIO: begin
          incReg   <= wrData[RATIO_W-1:0];
          fieldReg <= wrData[DATA_W-1:RATIO_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    modulus = incReg - fieldReg - RATIO_W'(1);
    ratioOk = (modulus != '0) && (modulus >= incReg);
    tickSel = baseIs44 ? tick44 : tick48;
    ctl.inc     = incReg;
    ctl.modulus = modulus;
    ctl.valid   = ratioOk;
    ctl.clear   = wrHit;
    ctl.tick    = tickSel && ratioOk && !wrHit;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> $stable({baseIs44, incReg, fieldReg})); // R9
endmodule

// File: rtl/rsg_acc.sv
module rsg_acc
  import rsg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  gen_ctl_t ctl,
  output logic     strobe
);
  logic [RATIO_W-1:0] acc;
  logic [RATIO_W:0]   sumWide;
  logic [RATIO_W:0]   diffWide;
  logic               wrap;
  logic [RATIO_W-1:0] accNext;

  always_comb begin
    sumWide  = {1'b0, acc} + {1'b0, ctl.inc};
    diffWide = sumWide - {1'b0, ctl.modulus};
    wrap     = sumWide >= {1'b0, ctl.modulus};
    accNext  = wrap ? diffWide[RATIO_W-1:0] : sumWide[RATIO_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (ctl.clear) begin
        acc <= '0;
      end else if (ctl.tick) begin
        acc    <= accNext;
        strobe <= wrap;
      end
    end
  end

  AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.valid |-> (acc < ctl.modulus)); // R4
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (acc == '0)); // R6
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.valid |=> !strobe); // R7
  AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> $past(ctl.tick)); // R10
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
  import rsg_pkg::*;
#(
  parameter  int unsigned NUM_GEN = 3,
  localparam int unsigned IDX_W   = (NUM_GEN > 1) ? $clog2(NUM_GEN + 1) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic               wrReg,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               tick44,
  input  logic               tick48,
  output logic [NUM_GEN-1:0] sampleStrobe
);
  logic [NUM_GEN-1:0] wrHit;

  for (genvar g = 0; g < NUM_GEN; g++) begin : gen_unit
    gen_ctl_t ctl;

    assign wrHit[g] = wrEn && (wrIdx == IDX_W'(g));

    rsg_ctrl i_ctrl (
      .clk    (clk),
      .rstN   (rstN),
      .wrHit  (wrHit[g]),
      .wrReg  (reg_sel_e'(wrReg)),
      .wrData (wrData),
      .tick44 (tick44),
      .tick48 (tick48),
      .ctl    (ctl)
    );

    rsg_acc i_acc (
      .clk    (clk),
      .rstN   (rstN),
      .ctl    (ctl),
      .strobe (sampleStrobe[g])
    );
  end

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrHit)); // R9
endmodule

// File: tb/test_rate_strobe_gen.sv
module test_rate_strobe_gen;
  localparam int NG = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic        wrReg = 1'b0;
  logic [31:0] wrData = '0;
  logic        tick44 = 1'b0;
  logic        tick48 = 1'b0;
  logic [NG-1:0] sampleStrobe;

  always #10 clk = ~clk;

  rate_strobe_gen #(.NUM_GEN(NG)) i_rate_strobe_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrReg(wrReg),
    .wrData(wrData), .tick44(tick44), .tick48(tick48),
    .sampleStrobe(sampleStrobe)
  );

  int     nVec = 0;
  int     nFail = 0;
  longint mInc[NG];
  longint mMod[NG];
  longint mK[NG];
  longint mCnt[NG];
  bit     mB44[NG];

  function automatic bit modelValid(int g);
    return (mMod[g] != 0) && (mMod[g] >= mInc[g]);
  endfunction

  task automatic step(bit we, int idx, bit rg, logic [31:0] d,
                      bit t44, bit t48, string tag);
    bit expv[NG];
    wrEn = we; wrIdx = 2'(idx); wrReg = rg; wrData = d;
    tick44 = t44; tick48 = t48;
    for (int g = 0; g < NG; g++) begin
      expv[g] = 1'b0;
      if (we && idx == g) begin
        if (rg == 1'b0) mB44[g] = d[0];
        else begin
          mInc[g] = longint'(d[15:0]);
          mMod[g] = (longint'(d[15:0]) - longint'(d[31:16]) - 1) & 64'hFFFF;
        end
        mK[g] = 0;
        mCnt[g] = 0;
      end else if ((mB44[g] ? t44 : t48) && modelValid(g)) begin
        mK[g]++;
        expv[g] = ((mK[g] * mInc[g]) / mMod[g]) != (((mK[g] - 1) * mInc[g]) / mMod[g]);
      end
    end
    @(negedge clk);
    for (int g = 0; g < NG; g++) begin
      nVec++;
      mCnt[g] += longint'(sampleStrobe[g]);
      if (sampleStrobe[g] !== expv[g]) begin
        nFail++;
        $display("FAIL %s gen%0d strobe actual=%b expected=%b (k=%0d inc=%0d mod=%0d)",
                 tag, g, sampleStrobe[g], expv[g], mK[g], mInc[g], mMod[g]);
      end
    end
  endtask

  task automatic wr(int idx, bit rg, logic [31:0] d, string tag);
    step(1'b1, idx, rg, d, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(string tag);
    step(1'b0, 0, 1'b0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  function automatic logic [31:0] ratioWord(int inc, int md);
    logic [15:0] f;
    f = 16'(inc - md - 1);
    return {f, 16'(inc)};
  endfunction

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      mInc[g] = 0; mMod[g] = 65535; mK[g] = 0; mCnt[g] = 0; mB44[g] = 1'b0;
    end
    // R1: reset state
    repeat (3) @(negedge clk);
    nVec++;
    if (sampleStrobe !== '0) begin
      nFail++;
      $display("FAIL R1 strobes in reset actual=%b expected=000", sampleStrobe);
    end
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) step(1'b0, 0, 1'b0, 32'h0, i[0], ~i[0], "R1");

    // R4, R5, R7, R2: sweep over increment, modulus and source
    for (int b = 0; b < 2; b++) begin
      for (int inc = 1; inc <= 4; inc++) begin
        for (int md = 1; md <= 9; md++) begin
          string tg;
          int n;
          tg = (md < inc) ? "R7" : "R4";
          wr(0, 1'b0, 32'(b), tg);
          wr(0, 1'b1, ratioWord(inc, md), tg);
          n = 2 * md + 3;
          for (int i = 0; i < n; i++) begin
            step(1'b0, 0, 1'b0, 32'h0, b == 1, b == 0, tg);
            step(1'b0, 0, 1'b0, 32'h0, b == 0, b == 1, "R2");
          end
          nVec++;
          if (mCnt[0] != ((md < inc) ? 0 : (longint'(n) * inc) / md)) begin
            nFail++;
            $display("FAIL R5 strobe count actual=%0d expected=%0d (inc=%0d mod=%0d)",
                     mCnt[0], (md < inc) ? 0 : (n * inc) / md, inc, md);
          end
        end
      end
    end

    // R7: modulus of zero
    wr(0, 1'b1, {16'd2, 16'd3}, "R7");
    for (int i = 0; i < 10; i++) step(1'b0, 0, 1'b0, 32'h0, 1'b1, 1'b1, "R7");

    // R3: full-width fields
    wr(0, 1'b0, 32'h1, "R3");
    wr(0, 1'b1, ratioWord(40000, 65535), "R3");
    for (int i = 0; i < 12; i++) step(1'b0, 0, 1'b0, 32'h0, 1'b1, 1'b0, "R3");
    wr(0, 1'b1, ratioWord(65535, 65535), "R3");
    for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b0, 32'h0, 1'b1, 1'b0, "R3");

    // R6: a rewrite mid-sequence restarts numbering
    wr(0, 1'b1, ratioWord(2, 5), "R6");
    for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b0, 32'h0, 1'b1, 1'b0, "R6");
    wr(0, 1'b0, 32'h1, "R6");
    for (int i = 0; i < 6; i++) step(1'b0, 0, 1'b0, 32'h0, 1'b1, 1'b0, "R6");

    // R8: write colliding with a selected tick
    step(1'b0, 0, 1'b0, 32'h0, 1'b1, 1'b0, "R8");
    step(1'b1, 0, 1'b1, ratioWord(1, 2), 1'b1, 1'b1, "R8");
    for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b0, 32'h0, 1'b1, 1'b0, "R8");

    // R9: independence of generators and out-of-range index
    wr(1, 1'b1, ratioWord(1, 2), "R9");
    wr(2, 1'b0, 32'h1, "R9");
    wr(2, 1'b1, ratioWord(2, 3), "R9");
    for (int i = 0; i < 24; i++) begin
      if (i == 7) step(1'b1, 0, 1'b1, ratioWord(3, 7), 1'b1, 1'b1, "R9");
      else if (i == 13) step(1'b1, 3, 1'b1, ratioWord(1, 1), 1'b1, 1'b0, "R9");
      else step(1'b0, 0, 1'b0, 32'h0, i % 3 != 0, i[0], "R9");
    end

    // R10: no ticks, no strobes
    for (int i = 0; i < 10; i++) idle("R10");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule